// File: doc/BRIEF.md
# Teletext Display Raster Timer

This block generates all line-rate and field-rate timing for a text display of 40 character columns by 25 text rows on a 625-line raster. It runs from a character clock of one tick per character cell, so one tick is 1 µs and a line lasts 64 ticks. From that clock it produces a line sync pulse, a display-enable window, the current character column, and the text row and scanline that the character generator should fetch. It also drives an odd/even field flag and a field sync.

Two mode bits choose the field structure:
- an interlaced pair of half-line-offset fields;
- a non-interlaced 312/313 pair;
- a 312/312 terminal raster;
- an external mode in which fields are restarted by an outside pulse rather than counted internally.

The 250 visible lines of each field are split into 25 text rows of 10 scanlines. Row 24, the status row, can be shown above or below the 24 main rows. Either the upper or the lower half of the main page can be stretched to fill the whole main area at double height.

Top module: `ttx_raster_timer`

## Requirements
- R1: `hsync_o` is high on character ticks 0 to 4 of every 64-tick line and low on ticks 5 to 63.
- R2: `de_o` is high only on ticks 17 to 56 of field lines 42 to 291, where field lines count from 1. While `de_o` is high, `col_o` equals tick minus 17 (0 to 39). Otherwise `col_o` is 0.
- R3: Each field ends after its last line and `odd_even_o` then toggles.
  - With `line_mode_i` 00, field 0 has 313 lines and field 1 has 312.
  - With 01, field 0 has 312 lines and field 1 has 313.
  - With 10, both fields have 312 lines.
- R4: `fsync_o` is high on field lines 1 to 3 in modes 01 and 10. In mode 00 the pulse for field 0 covers lines 1 to 3. The pulse for field 1 starts at tick 32 of the last line of field 0 and ends at tick 32 of line 3 of field 1.
- R5: With `status_top_i` 0 and `dbl_sel_i[0]` 0, visible line a (a = field line − 42) shows `row_o` = a/10 and `scan_o` = a mod 10. Rows 0 to 24 appear in order, with row 24 last. `row_o` and `scan_o` are 0 while `de_o` is low.
- R6: With `status_top_i` 1, the first 10 visible lines show row 24. Band k > 0 of the visible area shows row k−1.
- R7: With `dbl_sel_i` 01, main band m (0 to 23, status row excluded) at scanline s shows `row_o` = m/2 and `scan_o` = ((m mod 2)·10 + s)/2. Only rows 0 to 11 appear in the main area, and the status row is unchanged.
- R8: With `dbl_sel_i` 11, the mapping of R7 applies with `row_o` = 12 + m/2, so only rows 12 to 23 appear. With `dbl_sel_i` 00 or 10, the height is normal.
- R9: `odd_even_o` is high during field 1 and low during field 0. It is held low while `oe_force_low_i` is 1.
- R10: With `line_mode_i` 11:
  - `fsync_o` stays low and the field flag does not change.
  - At each line end the line count returns to 1 if `ext_vsync_i` was high at any tick of that line.
  - Otherwise the count advances and saturates at 511.
- R11: During reset the line is at tick 0 of line 1 of field 0. `hsync_o` and `fsync_o` are then high, `de_o` and `odd_even_o` are low, and `col_o`, `row_o` and `scan_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock, one tick per cell |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_mode_i | input | 2 | Field structure: 00 interlaced, 01 312/313, 10 312/312, 11 external |
| dbl_sel_i | input | 2 | Double height: x0 normal, 01 upper half, 11 lower half |
| status_top_i | input | 1 | 1 places row 24 above the main rows |
| oe_force_low_i | input | 1 | 1 holds the odd/even flag low |
| ext_vsync_i | input | 1 | Field restart request in external mode |
| hsync_o | output | 1 | Line sync pulse |
| de_o | output | 1 | Character display window |
| col_o | output | 6 | Character column |
| row_o | output | 5 | Text row to fetch |
| scan_o | output | 4 | Scanline within the fetched row |
| odd_even_o | output | 1 | Field flag |
| fsync_o | output | 1 | Field sync pulse |

## Verification
The hardest state to reach is the saturated line count in external mode. It requires more than 500 lines (over 32,000 ticks) with no restart pulse, and it must be followed by a pulse that lands in mid-line. The stimulus stays in mode 11 for that long, then pulses `ext_vsync_i` for a single tick far from a line boundary. The check is that the visible window reappears 41 lines after the next line end.

The bench also changes `line_mode_i` in the middle of a field, so that a field is shorter or longer than the mode it began in. It changes the row-mapping controls while the display window is open, and the behavioural reference tracks each case.

// File: rtl/ttx_raster_timer.sv
module ttx_raster_timer #(
  parameter int LINE_CLKS   = 64,
  parameter int HSYNC_CLKS  = 5,
  parameter int HACT_START  = 17,
  parameter int COLS        = 40,
  parameter int VACT_FIRST  = 42,
  parameter int TEXT_ROWS   = 25,
  parameter int SCANS       = 10,
  parameter int FIELD_SHORT = 312,
  parameter int VSYNC_LINES = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [1:0]                    line_mode_i,
  input  logic [1:0]                    dbl_sel_i,
  input  logic                          status_top_i,
  input  logic                          oe_force_low_i,
  input  logic                          ext_vsync_i,
  output logic                          hsync_o,
  output logic                          de_o,
  output logic [$clog2(COLS)-1:0]       col_o,
  output logic [$clog2(TEXT_ROWS)-1:0]  row_o,
  output logic [$clog2(SCANS)-1:0]      scan_o,
  output logic                          odd_even_o,
  output logic                          fsync_o
);
  localparam int HW = $clog2(LINE_CLKS);
  localparam int VW = $clog2(FIELD_SHORT + 2);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(TEXT_ROWS);
  localparam int SW = $clog2(SCANS);
  localparam int VACT_LAST = VACT_FIRST + TEXT_ROWS * SCANS - 1;
  localparam int MAIN_ROWS = TEXT_ROWS - 1;

  localparam logic [HW-1:0] H_LAST  = HW'(LINE_CLKS - 1);
  localparam logic [HW-1:0] H_HALF  = HW'(LINE_CLKS / 2);
  localparam logic [HW-1:0] H_SYNC  = HW'(HSYNC_CLKS);
  localparam logic [HW-1:0] H_ACT0  = HW'(HACT_START);
  localparam logic [HW-1:0] H_ACT1  = HW'(HACT_START + COLS);
  localparam logic [VW-1:0] V_ONE   = VW'(1);
  localparam logic [VW-1:0] V_MAX   = {VW{1'b1}};
  localparam logic [VW-1:0] V_FIRST = VW'(VACT_FIRST);
  localparam logic [VW-1:0] V_LAST  = VW'(VACT_LAST);
  localparam logic [VW-1:0] V_SYNC  = VW'(VSYNC_LINES);
  localparam logic [VW-1:0] F_SHORT = VW'(FIELD_SHORT);
  localparam logic [VW-1:0] F_LONG  = VW'(FIELD_SHORT + 1);
  localparam logic [SW-1:0] S_LAST  = SW'(SCANS - 1);
  localparam logic [RW-1:0] R_STAT  = RW'(TEXT_ROWS - 1);
  localparam logic [RW-1:0] R_HALF  = RW'(MAIN_ROWS / 2);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vline, vline_nx, flen;
  logic [SW-1:0] sl;
  logic [RW-1:0] slot, m;
  logic          fld, pend, hit, ext, line_end, field_end;
  logic          vact, hact, is_stat;
  logic [RW-1:0] row_map;
  logic [SW-1:0] scan_map;
  logic [SW:0]   dbl_sum;

  assign ext       = (line_mode_i == 2'b11);
  assign line_end  = (hcnt == H_LAST);
  assign hit       = pend | ext_vsync_i;

  always_comb begin
    case (line_mode_i)
      2'b00:   flen = fld ? F_SHORT : F_LONG;
      2'b01:   flen = fld ? F_LONG  : F_SHORT;
      default: flen = F_SHORT;
    endcase
  end

  assign field_end = !ext && (vline >= flen);

  always_comb begin
    if (ext)            vline_nx = hit ? V_ONE : ((vline != V_MAX) ? vline + V_ONE : vline);
    else if (field_end) vline_nx = V_ONE;
    else                vline_nx = vline + V_ONE;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      hcnt  <= '0;
      vline <= V_ONE;
      fld   <= 1'b0;
      sl    <= '0;
      slot  <= '0;
      pend  <= 1'b0;
    end else begin
      hcnt <= line_end ? '0 : hcnt + 1'b1;
      pend <= ext && !line_end && hit;
      if (line_end) begin
        vline <= vline_nx;
        if (field_end) fld <= ~fld;
        if (vline_nx == V_FIRST) begin
          sl   <= '0;
          slot <= '0;
        end else if (sl == S_LAST) begin
          sl   <= '0;
          slot <= slot + 1'b1;
        end else begin
          sl <= sl + 1'b1;
        end
      end
    end
  end

  assign vact = (vline >= V_FIRST) && (vline <= V_LAST);
  assign hact = (hcnt >= H_ACT0) && (hcnt < H_ACT1);

  assign is_stat = status_top_i ? (slot == '0) : (slot == R_STAT);
  assign m       = status_top_i ? slot - 1'b1 : slot;
  assign dbl_sum = (m[0] ? (SW+1)'(SCANS) : '0) + {1'b0, sl};

  always_comb begin
    if (is_stat) begin
      row_map  = R_STAT;
      scan_map = sl;
    end else if (dbl_sel_i[0]) begin
      row_map  = (m >> 1) + (dbl_sel_i[1] ? R_HALF : '0);
      scan_map = dbl_sum[SW:1];
    end else begin
      row_map  = m;
      scan_map = sl;
    end
  end

  assign hsync_o    = (hcnt < H_SYNC);
  assign de_o       = vact && hact;
  assign col_o      = de_o ? CW'(hcnt - H_ACT0) : '0;
  assign row_o      = de_o ? row_map : '0;
  assign scan_o     = de_o ? scan_map : '0;
  assign odd_even_o = fld && !oe_force_low_i;

  always_comb begin
    if (ext)
      fsync_o = 1'b0;
    else if (line_mode_i == 2'b00)
      fsync_o = fld ? ((vline < V_SYNC) || ((vline == V_SYNC) && (hcnt < H_HALF)))
                    : ((vline <= V_SYNC) || ((vline == flen) && (hcnt >= H_HALF)));
    else
      fsync_o = (vline <= V_SYNC);
  end
endmodule

// File: rtl/ttx_raster_timer_chk.sv
module ttx_raster_timer_chk #(
  parameter int COLS      = 40,
  parameter int TEXT_ROWS = 25,
  parameter int SCANS     = 10
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [1:0]                   line_mode_i,
  input logic [1:0]                   dbl_sel_i,
  input logic                         oe_force_low_i,
  input logic                         hsync_o,
  input logic                         de_o,
  input logic [$clog2(COLS)-1:0]      col_o,
  input logic [$clog2(TEXT_ROWS)-1:0] row_o,
  input logic [$clog2(SCANS)-1:0]     scan_o,
  input logic                         odd_even_o,
  input logic                         fsync_o
);
  localparam int HALF = (TEXT_ROWS - 1) / 2;

  AST_SYNC_NOT_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> !de_o); // R1
  AST_COL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && $past(de_o)) |-> (int'(col_o) == int'($past(col_o)) + 1)); // R2
  AST_COL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (int'(col_o) < COLS)); // R2
  AST_ROW_SCAN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> ((int'(row_o) < TEXT_ROWS) && (int'(scan_o) < SCANS))); // R5
  AST_DBL_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && dbl_sel_i == 2'b01 && int'(row_o) != TEXT_ROWS - 1) |-> (int'(row_o) < HALF)); // R7
  AST_DBL_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && dbl_sel_i == 2'b11 && int'(row_o) != TEXT_ROWS - 1) |-> (int'(row_o) >= HALF)); // R8
  AST_EXT_FIELD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_mode_i == 2'b11 && $past(line_mode_i) == 2'b11 && $stable(oe_force_low_i))
      |-> ($stable(odd_even_o) && !fsync_o)); // R10
endmodule

bind ttx_raster_timer ttx_raster_timer_chk #(
  .COLS(COLS), .TEXT_ROWS(TEXT_ROWS), .SCANS(SCANS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_mode_i(line_mode_i), .dbl_sel_i(dbl_sel_i),
  .oe_force_low_i(oe_force_low_i), .hsync_o(hsync_o), .de_o(de_o), .col_o(col_o),
  .row_o(row_o), .scan_o(scan_o), .odd_even_o(odd_even_o), .fsync_o(fsync_o)
);

// File: tb/ttx_raster_timer_test.sv
`timescale 1ns/1ps
module ttx_raster_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] dbl = 2'b00;
  logic       st_top = 1'b0;
  logic       oe_low = 1'b0;
  logic       ext = 1'b0;
  logic       hsync, de, oe, fsync;
  logic [5:0] col;
  logic [4:0] row;
  logic [3:0] scan;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  int h = 0, v = 1, f = 0, pend = 0;

  always #4 clk = ~clk;

  ttx_raster_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .line_mode_i(mode), .dbl_sel_i(dbl),
    .status_top_i(st_top), .oe_force_low_i(oe_low), .ext_vsync_i(ext),
    .hsync_o(hsync), .de_o(de), .col_o(col), .row_o(row), .scan_o(scan),
    .odd_even_o(oe), .fsync_o(fsync)
  );

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, nm, cycles, act, exp);
    end
  endtask

  // behavioural reference of the raster position
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      h = 0; v = 1; f = 0; pend = 0;
    end else begin
      int flen;
      int hitv;
      flen = (mode == 2'b00) ? (f ? 312 : 313) : (mode == 2'b01) ? (f ? 313 : 312) : 312;
      hitv = pend | ext;
      if (h == 63) begin
        if (mode == 2'b11) v = hitv ? 1 : ((v < 511) ? v + 1 : v);
        else if (v >= flen) begin v = 1; f ^= 1; end
        else v = v + 1;
        pend = 0;
        h = 0;
      end else begin
        pend = (mode == 2'b11) ? hitv : 0;
        h = h + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_de, e_col, e_row, e_scan, e_fs, flen;
      string rtag;
      flen = (mode == 2'b00) ? (f ? 312 : 313) : (mode == 2'b01) ? (f ? 313 : 312) : 312;
      e_de = (v >= 42 && v <= 291 && h >= 17 && h <= 56) ? 1 : 0;
      e_col = 0; e_row = 0; e_scan = 0;
      if (e_de) begin
        int a, s, l, mm, stat;
        a = v - 42; s = a / 10; l = a % 10;
        e_col = h - 17;
        if (st_top) begin stat = (s == 0); mm = s - 1; end
        else begin stat = (s == 24); mm = s; end
        if (stat) begin e_row = 24; e_scan = l; end
        else if (dbl[0]) begin
          e_row = (dbl[1] ? 12 : 0) + mm / 2;
          e_scan = ((mm % 2) * 10 + l) / 2;
        end else begin e_row = mm; e_scan = l; end
      end
      if (mode == 2'b11) e_fs = 0;
      else if (mode == 2'b00)
        e_fs = f ? ((v < 3 || (v == 3 && h < 32)) ? 1 : 0)
                 : ((v <= 3 || (v == flen && h >= 32)) ? 1 : 0);
      else e_fs = (v <= 3) ? 1 : 0;
      rtag = dbl[0] ? (dbl[1] ? "R8" : "R7") : (st_top ? "R6" : "R5");
      chk("R1", "hsync", hsync, (h < 5) ? 1 : 0);
      chk("R2", "de", de, e_de);
      chk("R2", "col", col, e_col);
      chk(rtag, "row", row, e_row);
      chk(rtag, "scan", scan, e_scan);
      chk((mode == 2'b11) ? "R10" : "R4", "fsync", fsync, e_fs);
      chk(oe_low ? "R9" : "R3", "odd_even", oe, oe_low ? 0 : f);
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int seen_de;
    run(3);
    // R11 reset state
    chk("R11", "hsync", hsync, 1);
    chk("R11", "de", de, 0);
    chk("R11", "fsync", fsync, 1);
    chk("R11", "odd_even", oe, 0);
    chk("R11", "col", col, 0);
    chk("R11", "row", row, 0);
    chk("R11", "scan", scan, 0);
    rst_n = 1'b1;
    run(41000);                               // interlaced, normal rows
    mode = 2'b01; dbl = 2'b01; st_top = 1'b1; // R3 R6 R7
    run(40100);
    mode = 2'b10; dbl = 2'b11; st_top = 1'b0; oe_low = 1'b1; // R8 R9
    run(40100);
    oe_low = 1'b0; dbl = 2'b10;
    mode = 2'b11;                             // R10
    run(3030);
    ext = 1'b1; run(1); ext = 1'b0;
    run(4000);
    run(33000);
    // R10: saturated count, window must be closed
    seen_de = 0;
    repeat (64) begin @(negedge clk); seen_de |= de; end
    chk("R10", "saturated_de", seen_de, 0);
    run(17);
    ext = 1'b1; run(1); ext = 1'b0;
    run(3000);
    mode = 2'b00; dbl = 2'b00;
    run(3000);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule